// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Control Core

This block is the control and interrupt part of a CMOS-style real-time clock. A 32.768 kHz tick enable drives two counting chains. The first is a free-running prescaler that raises a periodic event at a power-of-two rate chosen by software. The second is a one-second sequencer that advances the seconds, minutes and hours fields. Just before each advance, the sequencer opens an update-in-progress window so that software knows not to read the time fields during it.

Software reaches every register through one index port, with a write strobe and a read strobe. The read data follows the index in the same cycle, and the read strobe only matters for the flag register. Three event flags (periodic, alarm and update-ended) set when their events occur. A summary bit combines each flag with its enable, and that bit drives the interrupt request output. Reading the flag register with the strobe clears every flag. The time fields count in BCD or in binary, selected by a mode bit. An alarm compares the new time against three alarm fields at each update.

Top module: `rtc_core`

## Requirements
- R1: Register indices are: seconds 0x0, seconds alarm 0x1, minutes 0x2, minutes alarm 0x3, hours 0x4, hours alarm 0x5, control A 0xA, control B 0xB, flags 0xC, status 0xD. All other indices read 0. `reg_rdata` shows the indexed register in the same cycle. A write takes effect at the clock edge.
- R2: After reset: control A reads 0x20, control B reads 0x00, flags read 0x00, time and alarm fields are 0, and `irq_o` is low. Status always reads 0x80. Writes to the flag register and the status register have no effect. Bit 7 of control A ignores writes.
- R3: Control A bits 6:4 select the divider. The value 010 lets both chains count `tick_en` pulses. Any other value holds both chains at zero, so no event occurs while stopped and counting restarts from zero.
- R4: Control A bits 3:0 hold the rate code c. For c from 3 to 15, the periodic event occurs every 2^(c-1) ticks. Codes 1 and 2 give 128 and 256 ticks. Code 0 gives no event. After the chain starts, the first event falls on tick 2^(c-1). Each event sets the periodic flag (flags bit 6).
- R5: The time advances by one second every TICKS_PER_SEC ticks. Control A bit 7 (update in progress) is high during the last UIP_TICKS ticks before each advance, and low at all other times.
- R6: Control B bit 2 selects the count format: 0 = BCD, 1 = binary. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one into the next field.
- R7: Control B bit 7 set halts the one-second chain. The time does not advance, the update-in-progress bit stays low, and the update and alarm flags stay clear. The periodic chain is unaffected.
- R8: Each advance sets the update flag (flags bit 4). The alarm flag (flags bit 5) sets when the advanced seconds, minutes and hours all equal their alarm fields.
- R9: Flags bit 7 equals (periodic & B6) | (alarm & B5) | (update & B4). `irq_o` equals flags bit 7, including right after an enable changes. Bits 3:0 of the flag register read 0.
- R10: A read strobe at index 0xC returns the flags and clears all of them at that edge. If an event occurs in the same cycle, its flag is set instead of cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz base tick |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears the flags at index 0xC |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench reads a register shortly after an edge without spending a cycle. A register write, a flag clear, an advance and a flag set all appear right after the edge that causes them. Each timing check counts edges from the write that starts a chain. The periodic event is due on edge 2^(c-1) after that write. The update-in-progress bit is due on edge TICKS_PER_SEC-UIP_TICKS, and the advance with its flags on edge TICKS_PER_SEC. The bench samples one edge before each of these as well as at it, so an off-by-one in either direction is reported.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;
    localparam int PER_W  = 15;

    localparam logic [IDX_W-1:0] IDX_SEC  = 4'h0;
    localparam logic [IDX_W-1:0] IDX_ASEC = 4'h1;
    localparam logic [IDX_W-1:0] IDX_MIN  = 4'h2;
    localparam logic [IDX_W-1:0] IDX_AMIN = 4'h3;
    localparam logic [IDX_W-1:0] IDX_HR   = 4'h4;
    localparam logic [IDX_W-1:0] IDX_AHR  = 4'h5;
    localparam logic [IDX_W-1:0] IDX_CTLA = 4'hA;
    localparam logic [IDX_W-1:0] IDX_CTLB = 4'hB;
    localparam logic [IDX_W-1:0] IDX_FLAG = 4'hC;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'hD;

    localparam logic [2:0] DIV_RUN = 3'b010;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] s;
        logic [DATA_W-1:0] m;
        logic [DATA_W-1:0] h;
    } hms_t;

    // mask with the low n bits set, n from the rate code (R4)
    function automatic logic [PER_W-1:0] rate_mask(input logic [3:0] code);
        int n;
        if (code == 4'd0)      n = 0;
        else if (code < 4'd3)  n = int'(code) + 6;
        else                   n = int'(code) - 1;
        return (PER_W'(1) << n) - PER_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] field_limit(input int maxv, input logic bcd);
        return bcd ? {4'(maxv / 10), 4'(maxv % 10)} : DATA_W'(maxv);
    endfunction

    function automatic logic field_last(input logic [DATA_W-1:0] v, input int maxv,
                                        input logic bcd);
        return v == field_limit(maxv, bcd);
    endfunction

    function automatic logic [DATA_W-1:0] field_next(input logic [DATA_W-1:0] v,
                                                    input int maxv, input logic bcd);
        if (field_last(v, maxv, bcd))     return '0;
        if (bcd && v[3:0] == 4'd9)        return {v[7:4] + 4'd1, 4'd0};
        return v + DATA_W'(1);
    endfunction
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic [3:0] rate_code,
    output logic       per_evt
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } st_t;

    st_t              s_q, s_d;
    logic [PER_W-1:0] mask;

    always_comb begin
        s_d     = s_q;
        mask    = rate_mask(rate_code);
        per_evt = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (tick_en) begin
            s_d.cnt = s_q.cnt + PER_W'(1);
            per_evt = (rate_code != 4'd0) && ((s_q.cnt & mask) == mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic halt,
    output logic uip,
    output logic upd_evt
);
    localparam int CNT_W     = $clog2(TICKS_PER_SEC);
    localparam int LAST      = TICKS_PER_SEC - 1;
    localparam int UIP_START = TICKS_PER_SEC - UIP_TICKS;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        upd_evt = 1'b0;
        uip     = run && !halt && (s_q.cnt >= CNT_W'(UIP_START));
        if (!run || halt) begin
            s_d.cnt = '0;
        end else if (tick_en) begin
            if (s_q.cnt == CNT_W'(LAST)) begin
                s_d.cnt = '0;
                upd_evt = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_evt,
    input  logic              bcd_mode,
    output hms_t              now,
    output logic              alarm_hit
);
    typedef struct packed {
        hms_t cur;
        hms_t alm;
    } st_t;

    st_t  s_q, s_d;
    hms_t bumped;
    logic last_s, last_m;

    always_comb begin
        s_d      = s_q;
        last_s   = field_last(s_q.cur.s, 59, bcd_mode);
        last_m   = field_last(s_q.cur.m, 59, bcd_mode);
        bumped.s = field_next(s_q.cur.s, 59, bcd_mode);
        bumped.m = last_s ? field_next(s_q.cur.m, 59, bcd_mode) : s_q.cur.m;
        bumped.h = (last_s && last_m) ? field_next(s_q.cur.h, 23, bcd_mode) : s_q.cur.h;
        alarm_hit = upd_evt && (bumped == s_q.alm);
        if (upd_evt) s_d.cur = bumped;
        if (wr_en) begin
            case (wr_idx)
                IDX_SEC:  s_d.cur.s = wr_data;
                IDX_MIN:  s_d.cur.m = wr_data;
                IDX_HR:   s_d.cur.h = wr_data;
                IDX_ASEC: s_d.alm.s = wr_data;
                IDX_AMIN: s_d.alm.m = wr_data;
                IDX_AHR:  s_d.alm.h = wr_data;
                default:  ;
            endcase
        end
        now = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic [6:0]        ctla;
        logic [DATA_W-1:0] ctlb;
        flags_t            flags;
    } st_t;

    localparam st_t RST_VAL = '{ctla: {DIV_RUN, 4'h0}, ctlb: '0, flags: '0};

    st_t  s_q, s_d;
    logic run, halt, bcd_mode;
    logic per_evt, upd_evt, uip, alarm_hit, irqf;
    logic [2:0] flag_vec;
    logic [2:0] irq_en;
    hms_t now;

    assign run      = (s_q.ctla[6:4] == DIV_RUN);
    assign halt     = s_q.ctlb[7];
    assign bcd_mode = ~s_q.ctlb[2];
    assign flag_vec = s_q.flags;
    assign irq_en   = s_q.ctlb[6:4];

    rtc_rate_div u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (run),
        .rate_code (s_q.ctla[3:0]),
        .per_evt   (per_evt)
    );

    rtc_update_seq #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (run),
        .halt    (halt),
        .uip     (uip),
        .upd_evt (upd_evt)
    );

    rtc_time_core u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_idx    (reg_idx),
        .wr_data   (reg_wdata),
        .upd_evt   (upd_evt),
        .bcd_mode  (bcd_mode),
        .now       (now),
        .alarm_hit (alarm_hit)
    );

    // next state: control writes, read-to-clear, then events win (R10)
    always_comb begin
        s_d = s_q;
        if (reg_wr && reg_idx == IDX_CTLA) s_d.ctla = reg_wdata[6:0];
        if (reg_wr && reg_idx == IDX_CTLB) s_d.ctlb = reg_wdata;
        if (reg_rd && reg_idx == IDX_FLAG) s_d.flags = '0;
        if (per_evt)   s_d.flags.pf = 1'b1;
        if (alarm_hit) s_d.flags.af = 1'b1;
        if (upd_evt)   s_d.flags.uf = 1'b1;
    end

    always_comb begin
        irqf  = |(flag_vec & irq_en);
        irq_o = irqf;
        case (reg_idx)
            IDX_SEC:  reg_rdata = now.s;
            IDX_MIN:  reg_rdata = now.m;
            IDX_HR:   reg_rdata = now.h;
            IDX_CTLA: reg_rdata = {uip, s_q.ctla};
            IDX_CTLB: reg_rdata = s_q.ctlb;
            IDX_FLAG: reg_rdata = {irqf, flag_vec, 4'h0};
            IDX_STAT: reg_rdata = 8'h80;
            default:  reg_rdata = alarm_read(reg_idx);
        endcase
    end

    function automatic logic [DATA_W-1:0] alarm_read(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_ASEC: return u_time.s_q.alm.s;
            IDX_AMIN: return u_time.s_q.alm.m;
            IDX_AHR:  return u_time.s_q.alm.h;
            default:  return '0;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_idx,
    input logic       irq_o,
    input logic       uip,
    input logic       halt,
    input logic [7:0] sec,
    input logic [2:0] flags,
    input logic       per_evt,
    input logic       upd_evt
);
    // R5: seconds only move by an update while the window is open, or by a write
    a_r5_advance_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sec) && !$past(reg_wr)) |-> $past(uip));

    // R7: halted and not written, seconds hold
    a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reg_wr) |=> $stable(sec));

    // R10: strobed flag read with no event empties the flags
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_idx == rtc_pkg::IDX_FLAG && !per_evt && !upd_evt) |=> (flags == 3'b000));

    // R4: periodic flag rises only after a periodic event
    a_r4_pf_from_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(per_evt));

    // R8: update flag rises only after an update
    a_r8_uf_from_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(upd_evt));

    // R9: a request needs a pending flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != 3'b000));
endmodule

bind rtc_core rtc_core_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_idx (reg_idx),
    .irq_o   (irq_o),
    .uip     (uip),
    .halt    (halt),
    .sec     (now.s),
    .flags   (flag_vec),
    .per_evt (per_evt),
    .upd_evt (upd_evt)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
    localparam int TPS  = 1024;
    localparam int UIPT = 8;

    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_idx = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    rtc_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut_i (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_idx (reg_idx), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_o (irq_o)
    );

    // sec, min, hr in; expected sec, min, hr, flags after one update; B value
    typedef struct packed {
        logic [7:0] b, s, m, h, es, em, eh, ec;
    } tv_t;
    localparam tv_t TV [6] = '{
        '{8'h00, 8'h09, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h10},
        '{8'h00, 8'h59, 8'h59, 8'h23, 8'h00, 8'h00, 8'h00, 8'h30},
        '{8'h00, 8'h59, 8'h14, 8'h09, 8'h00, 8'h15, 8'h09, 8'h10},
        '{8'h04, 8'd59, 8'd5,  8'd7,  8'd0,  8'd6,  8'd7,  8'h10},
        '{8'h04, 8'd59, 8'd59, 8'd23, 8'd0,  8'd0,  8'd0,  8'h30},
        '{8'h04, 8'd10, 8'd0,  8'd0,  8'd11, 8'd0,  8'd0,  8'h10}
    };
    localparam int RCODE [7] = '{3, 4, 6, 13, 15, 1, 2};
    localparam int RTICK [7] = '{4, 8, 32, 4096, 16384, 128, 256};

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chki(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [7:0] v);
        reg_idx = idx; #1;
        v = reg_rdata;
    endtask

    task automatic rdc(output logic [7:0] v);
        reg_idx = 4'hC; reg_rd = 1'b1; #1;
        v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        step(3);
        rst_n = 1'b1;
        #1;
        // R2 reset state, R1 map
        peek(4'hA, v); chk8("R2 ctl A reset", v, 8'h20);
        peek(4'hB, v); chk8("R2 ctl B reset", v, 8'h00);
        peek(4'hC, v); chk8("R2 flags reset", v, 8'h00);
        peek(4'hD, v); chk8("R2 status", v, 8'h80);
        peek(4'h0, v); chk8("R2 seconds reset", v, 8'h00);
        peek(4'h5, v); chk8("R2 hour alarm reset", v, 8'h00);
        chk8("R2 irq reset", {7'd0, irq_o}, 8'h00);
        peek(4'h7, v); chk8("R1 unmapped index", v, 8'h00);

        // R1/R2 ignored writes
        wr(4'hA, 8'h60); rdc(v);
        wr(4'hC, 8'hFF); peek(4'hC, v); chk8("R2 flag write ignored", v, 8'h00);
        wr(4'hD, 8'h00); peek(4'hD, v); chk8("R2 status write ignored", v, 8'h80);
        wr(4'hA, 8'hE5); peek(4'hA, v); chk8("R2 ctl A bit7 ignored", v, 8'h65);
        wr(4'h3, 8'h27); peek(4'h3, v); chk8("R1 minute alarm index", v, 8'h27);
        wr(4'h3, 8'h00);

        // R6/R8 table of one-second updates
        foreach (TV[i]) begin
            wr(4'hA, 8'h60); wr(4'hB, TV[i].b);
            wr(4'h0, TV[i].s); wr(4'h2, TV[i].m); wr(4'h4, TV[i].h);
            rdc(v);
            wr(4'hA, 8'h20);
            step(TPS - 1);
            peek(4'h0, v); chk8("R5 no advance before period", v, TV[i].s);
            step(1);
            peek(4'h0, v); chk8("R6 seconds", v, TV[i].es);
            peek(4'h2, v); chk8("R6 minutes", v, TV[i].em);
            peek(4'h4, v); chk8("R6 hours", v, TV[i].eh);
            chk8("R9 no irq without enable", {7'd0, irq_o}, 8'h00);
            rdc(v); chk8("R8 flags after update", v, TV[i].ec);
        end

        // R5 update-in-progress window, R9/R10 request and clear
        wr(4'hA, 8'h60); wr(4'hB, 8'h30);
        wr(4'h0, 8'h00); wr(4'h2, 8'h00); wr(4'h4, 8'h00);
        rdc(v);
        wr(4'hA, 8'h20);
        step(TPS - UIPT - 1);
        peek(4'hA, v); chk8("R5 window not yet open", v, 8'h20);
        step(1);
        peek(4'hA, v); chk8("R5 window open", v, 8'hA0);
        step(UIPT - 1);
        peek(4'hA, v); chk8("R5 window still open", v, 8'hA0);
        step(1);
        peek(4'hA, v); chk8("R5 window closed after advance", v, 8'h20);
        peek(4'h0, v); chk8("R5 seconds advanced", v, 8'h01);
        chk8("R9 irq on update", {7'd0, irq_o}, 8'h01);
        rdc(v); chk8("R10 read returns flags", v, 8'h90);
        chk8("R10 irq drops after read", {7'd0, irq_o}, 8'h00);
        peek(4'hC, v); chk8("R10 flags cleared", v, 8'h00);

        // R8 alarm full match then partial match
        wr(4'hA, 8'h60); wr(4'hB, 8'h20);
        wr(4'h1, 8'h05); wr(4'h3, 8'h00); wr(4'h5, 8'h00);
        wr(4'h0, 8'h04); wr(4'h2, 8'h00); wr(4'h4, 8'h00);
        rdc(v);
        wr(4'hA, 8'h20);
        step(TPS);
        chk8("R8 alarm irq", {7'd0, irq_o}, 8'h01);
        rdc(v); chk8("R8 alarm flags", v, 8'hB0);
        wr(4'hA, 8'h60); wr(4'h3, 8'h01); wr(4'h0, 8'h04); rdc(v);
        wr(4'hA, 8'h20);
        step(TPS);
        rdc(v); chk8("R8 partial match no alarm", v, 8'h10);

        // R7 halt: time frozen, window low, periodic still runs
        wr(4'hA, 8'h63); wr(4'hB, 8'h80); wr(4'h0, 8'h05); rdc(v);
        wr(4'hA, 8'h23);
        step(TPS + 50);
        peek(4'h0, v); chk8("R7 seconds held", v, 8'h05);
        peek(4'hA, v); chk8("R7 window low", v, 8'h23);
        peek(4'hC, v); chk8("R7 only periodic flag", v, 8'h40);
        chk8("R9 periodic masked", {7'd0, irq_o}, 8'h00);
        wr(4'hB, 8'hC0);
        chk8("R9 irq follows new enable", {7'd0, irq_o}, 8'h01);
        peek(4'hC, v); chk8("R9 summary bit", v, 8'hC0);

        // R3 stopped divider holds and restarts periodic chain
        wr(4'hB, 8'h40); wr(4'hA, 8'h63); rdc(v);
        step(50);
        chk8("R3 no event while stopped", {7'd0, irq_o}, 8'h00);
        wr(4'hA, 8'h23);
        step(3);
        chk8("R3 restart one tick early", {7'd0, irq_o}, 8'h00);
        step(1);
        chk8("R3 restart from zero", {7'd0, irq_o}, 8'h01);

        // R4 rate table
        foreach (RCODE[i]) begin
            wr(4'hA, {4'h6, 4'(RCODE[i])}); rdc(v);
            wr(4'hA, {4'h2, 4'(RCODE[i])});
            cnt = 0;
            while (!irq_o && cnt < RTICK[i] + 10) begin step(1); cnt++; end
            chki($sformatf("R4 period code %0d", RCODE[i]), cnt, RTICK[i]);
        end
        wr(4'hA, 8'h60); rdc(v); wr(4'hA, 8'h20);
        step(300);
        chk8("R4 code 0 no periodic", {7'd0, irq_o}, 8'h00);

        summary();
        $finish;
    end
endmodule